// File: doc/BRIEF.md
# DMA Channel Register File

This block is the processor-facing register bank of a four-channel DMA controller. A host programs it through an 8-bit data port with a 4-bit register address, an active-low select and active-low read and write strobes. Programming is allowed only while the controller does not own the bus, which means the hold-acknowledge input is low. Each channel has a 16-bit start address and a 16-bit transfer count. Each of these keeps a base copy and a working (current) copy. Because the port is only 8 bits wide, the two bytes of each 16-bit value are reached one after the other through an internal byte pointer.

The upper half of the address space holds the shared registers: command, mode, mask, request, status and a temporary data byte. It also holds several data-less commands, such as resetting the byte pointer, a full master clear and unmasking every channel. All register contents are brought out in parallel to the transfer engine. The engine reports terminal-count or end-of-process events, live per-channel requests, updated working address and count values, and the temporary byte in return.

Top module: `dma_regfile`

## Requirements
- R1: A register write takes effect only on the rising edge of `iow_n`, and only when `cs_n` and `hlda` are both low at that edge. With `hlda` high, writes leave every register unchanged.
- R2: When `addr[3]`=0, `addr[2:1]` selects the channel and `addr[0]` selects address (0) or count (1). The byte pointer starts at 0 (low byte), selects the high byte when it is 1, and toggles once per completed read or write strobe to these offsets.
- R3: A host write to a channel address or count loads both its base and current copies. A read returns the current copy. The base copy changes only through host writes.
- R4: A write to offset 8 loads the 8-bit command register, which is driven onto `cmd`.
- R5: A write to offset 9 sets (`din[2]`=1) or clears (`din[2]`=0) the software request of the channel given by `din[1:0]`.
- R6: Mask control works as follows. Offset A sets or clears one mask bit: `din[1:0]` selects the channel and `din[2]` is the value. Offset E clears all four mask bits. Offset F loads `din[3:0]`, where bit n belongs to channel n.
- R7: A write to offset B stores `din[7:2]` as the 6-bit mode of channel `din[1:0]`. The stored mode appears on `mode_all[6n+5:6n]`, with mode bit 2 (written as `din[4]`) meaning autoinitialize.
- R8: A write to offset C resets the byte pointer to the low byte. A write to offset D (master clear), like reset, zeroes the command register, TC flags, requests, temporary byte and byte pointer, and sets all mask bits.
- R9: A read at offset 8 returns status. Bits 3:0 are the per-channel TC flags. Bits 7:4 are `eng_dreq | sw_req`. A completed status read clears the TC flags.
- R10: An `eng_tc[n]` pulse has these effects on the next cycle: TC flag n is set, software request n is cleared, and mask bit n is set unless channel n has autoinitialize enabled.
- R11: On an `eng_tc[n]` pulse with autoinitialize enabled, channel n's current address and count are reloaded from its base copies.
- R12: `eng_cur_we` writes `eng_cur_addr`/`eng_cur_cnt` into the current copies of channel `eng_cur_ch`. `eng_tmp_we` loads the temporary byte, which is read at offset D. Reads outside the programming condition return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select |
| ior_n | input | 1 | Active-low read strobe |
| iow_n | input | 1 | Active-low write strobe |
| hlda | input | 1 | Bus granted to the controller; blocks programming |
| addr | input | 4 | Register address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| eng_tc | input | 4 | Per-channel terminal count / end-of-process pulse |
| eng_dreq | input | 4 | Live hardware requests, reflected in status |
| eng_cur_we | input | 1 | Engine update of a channel's current copies |
| eng_cur_ch | input | 2 | Channel for the engine update |
| eng_cur_addr | input | 16 | New current address |
| eng_cur_cnt | input | 16 | New current count |
| eng_tmp_we | input | 1 | Load the temporary byte |
| eng_tmp_d | input | 8 | Temporary byte value |
| cmd | output | 8 | Command register |
| mode_all | output | 24 | Four 6-bit modes, channel n at [6n+5:6n] |
| mask | output | 4 | Mask bits |
| sw_req | output | 4 | Software request bits |
| base_addr_all | output | 64 | Base addresses, channel n at [16n+15:16n] |
| cur_addr_all | output | 64 | Current addresses |
| base_cnt_all | output | 64 | Base counts |
| cur_cnt_all | output | 64 | Current counts |

## Verification
The embedded properties are checked on every cycle. They cover four things: configuration stays frozen while `hlda` is high; the byte pointer flips on every completed channel access; base copies stay untouched unless the host writes them; and master clear and TC pulses have their stated effect one cycle later. The scenarios cover what the properties cannot: byte ordering across a write and readback, the exact decoding of each shared offset, autoinitialize restoring values that the engine changed, status read-to-clear, and pointer recovery through the clear command.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic              hlda,
  input  logic [3:0]        addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  input  logic [NCH-1:0]    eng_tc,
  input  logic [NCH-1:0]    eng_dreq,
  input  logic              eng_cur_we,
  input  logic [1:0]        eng_cur_ch,
  input  logic [AW-1:0]     eng_cur_addr,
  input  logic [AW-1:0]     eng_cur_cnt,
  input  logic              eng_tmp_we,
  input  logic [7:0]        eng_tmp_d,
  output logic [7:0]        cmd,
  output logic [6*NCH-1:0]  mode_all,
  output logic [NCH-1:0]    mask,
  output logic [NCH-1:0]    sw_req,
  output logic [AW*NCH-1:0] base_addr_all,
  output logic [AW*NCH-1:0] cur_addr_all,
  output logic [AW*NCH-1:0] base_cnt_all,
  output logic [AW*NCH-1:0] cur_cnt_all
);

  logic [AW-1:0] base_a [NCH];
  logic [AW-1:0] cur_a  [NCH];
  logic [AW-1:0] base_c [NCH];
  logic [AW-1:0] cur_c  [NCH];
  logic [5:0]    mode   [NCH];
  logic [NCH-1:0] tcf;
  logic [7:0]    temp;
  logic          ptr, iow_q, ior_q;

  wire       prog  = !cs_n && !hlda;
  wire       wr_go = prog && !iow_q && iow_n;
  wire       rd_go = prog && !ior_q && ior_n;
  wire [1:0] ch    = addr[2:1];
  wire [AW-1:0] rd_word = addr[0] ? cur_c[ch] : cur_a[ch];

  always_ff @(posedge clk) begin
    if (rst) begin
      iow_q <= 1'b1;
      ior_q <= 1'b1;
      ptr   <= 1'b0;
      cmd   <= '0;
      tcf   <= '0;
      sw_req <= '0;
      temp  <= '0;
      mask  <= '1;
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0; cur_a[i] <= '0;
        base_c[i] <= '0; cur_c[i] <= '0;
        mode[i]   <= '0;
      end
    end else begin
      iow_q <= iow_n;
      ior_q <= ior_n;
      if (eng_tmp_we) temp <= eng_tmp_d;
      if (eng_cur_we) begin
        cur_a[eng_cur_ch] <= eng_cur_addr;
        cur_c[eng_cur_ch] <= eng_cur_cnt;
      end
      if (rd_go) begin
        if (!addr[3]) ptr <= ~ptr;
        else if (addr == 4'h8) tcf <= '0;
      end
      if (wr_go) begin
        if (!addr[3]) begin
          ptr <= ~ptr;
          if (!addr[0]) begin
            if (ptr) begin base_a[ch][15:8] <= din; cur_a[ch][15:8] <= din; end
            else     begin base_a[ch][7:0]  <= din; cur_a[ch][7:0]  <= din; end
          end else begin
            if (ptr) begin base_c[ch][15:8] <= din; cur_c[ch][15:8] <= din; end
            else     begin base_c[ch][7:0]  <= din; cur_c[ch][7:0]  <= din; end
          end
        end else begin
          case (addr[2:0])
            3'd0: cmd <= din;
            3'd1: sw_req[din[1:0]] <= din[2];
            3'd2: mask[din[1:0]] <= din[2];
            3'd3: mode[din[1:0]] <= din[7:2];
            3'd4: ptr <= 1'b0;
            3'd5: begin
              cmd <= '0; tcf <= '0; sw_req <= '0; temp <= '0;
              ptr <= 1'b0; mask <= '1;
            end
            3'd6: mask <= '0;
            default: mask <= din[NCH-1:0];
          endcase
        end
      end
      for (int i = 0; i < NCH; i++) begin
        if (eng_tc[i]) begin
          tcf[i]    <= 1'b1;
          sw_req[i] <= 1'b0;
          if (mode[i][2]) begin
            cur_a[i] <= base_a[i];
            cur_c[i] <= base_c[i];
          end else begin
            mask[i] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    dout = '0;
    if (prog && !ior_n) begin
      if (!addr[3])           dout = ptr ? rd_word[15:8] : rd_word[7:0];
      else if (addr == 4'h8)  dout = {eng_dreq | sw_req, tcf};
      else if (addr == 4'hD)  dout = temp;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign mode_all[6*g +: 6]       = mode[g];
    assign base_addr_all[AW*g +: AW] = base_a[g];
    assign cur_addr_all[AW*g +: AW]  = cur_a[g];
    assign base_cnt_all[AW*g +: AW]  = base_c[g];
    assign cur_cnt_all[AW*g +: AW]   = cur_c[g];
  end

  p_gate_r1: assert property (@(posedge clk) disable iff (rst)
    hlda |=> $stable(cmd) && $stable(mode_all));

  p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_go || rd_go) && !addr[3] |=> ptr != $past(ptr));

  p_base_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_go && !addr[3]) |=> $stable(base_addr_all) && $stable(base_cnt_all));

  p_mclr_r8: assert property (@(posedge clk) disable iff (rst)
    wr_go && addr == 4'hD |=> mask == '1 && cmd == '0 && sw_req == '0 && !ptr);

  p_tc_r10: assert property (@(posedge clk) disable iff (rst)
    eng_tc != '0 |=> ((tcf & $past(eng_tc)) == $past(eng_tc)) && ((sw_req & $past(eng_tc)) == '0));

endmodule

// File: tb/dma_regfile_tb.sv
`timescale 1ns/1ps
module dma_regfile_tb;
  logic clk = 0, rst = 1;
  logic cs_n = 1, ior_n = 1, iow_n = 1, hlda = 0;
  logic [3:0] addr = 0;
  logic [7:0] din = 0, dout;
  logic [3:0] eng_tc = 0, eng_dreq = 0;
  logic eng_cur_we = 0, eng_tmp_we = 0;
  logic [1:0] eng_cur_ch = 0;
  logic [15:0] eng_cur_addr = 0, eng_cur_cnt = 0;
  logic [7:0] eng_tmp_d = 0, cmd;
  logic [23:0] mode_all;
  logic [3:0] mask, sw_req;
  logic [63:0] base_addr_all, cur_addr_all, base_cnt_all, cur_cnt_all;

  int n_cmp = 0, n_bad = 0;
  logic smp = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  dma_regfile u_dut (.*);

  always @(negedge clk) if (smp) begin
    automatic logic [7:0] e = exp_q.pop_front();
    automatic string t = tag_q.pop_front();
    n_cmp++;
    if (dout !== e) begin
      n_bad++;
      $display("FAIL %s: dout=%h expected=%h", t, dout, e);
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string t);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic h = 0);
    @(posedge clk); #1 addr = a; din = d; hlda = h; cs_n = 0; iow_n = 0;
    @(posedge clk); #1 iow_n = 1;
    @(posedge clk); #1 cs_n = 1; hlda = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1 addr = a; cs_n = 0; ior_n = 0; smp = 1;
    @(posedge clk); #1 smp = 0; ior_n = 1;
    @(posedge clk); #1 cs_n = 1;
  endtask

  task automatic tc(input logic [3:0] m);
    @(posedge clk); #1 eng_tc = m;
    @(posedge clk); #1 eng_tc = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R8 reset state
    chk(mask, 4'hF, "R8 reset mask");
    chk(cmd, 8'h00, "R8 reset cmd");
    rd(4'h8, 8'h00, "R9 reset status");
    // R2 R3 byte order and readback
    wr(4'h2, 8'h34); wr(4'h2, 8'h12);
    wr(4'h3, 8'h05); wr(4'h3, 8'h00);
    rd(4'h2, 8'h34, "R2 ch1 addr low");
    rd(4'h2, 8'h12, "R2 ch1 addr high");
    rd(4'h3, 8'h05, "R3 ch1 count low");
    rd(4'h3, 8'h00, "R3 ch1 count high");
    chk(base_addr_all[31:16], 16'h1234, "R3 base ch1 addr");
    // R1 gating by hlda, R4 command
    wr(4'h8, 8'hFF, 1'b1);
    chk(cmd, 8'h00, "R1 write blocked by hlda");
    wr(4'h8, 8'h55);
    chk(cmd, 8'h55, "R4 command write");
    // R7 mode
    wr(4'hB, 8'h11);
    chk(mode_all[11:6], 6'h04, "R7 ch1 mode autoinit");
    wr(4'hB, 8'hA2);
    chk(mode_all[17:12], 6'h28, "R7 ch2 mode");
    // R6 masks
    wr(4'hE, 8'h00); chk(mask, 4'h0, "R6 clear all masks");
    wr(4'hA, 8'h06); chk(mask, 4'h4, "R6 single mask set ch2");
    wr(4'hF, 8'h09); chk(mask, 4'h9, "R6 all-mask load");
    wr(4'hA, 8'h03); chk(mask, 4'h1, "R6 single mask clear ch3");
    wr(4'hE, 8'h00);
    // R5 request, R9 status upper
    wr(4'h9, 8'h07); chk(sw_req, 4'h8, "R5 request set ch3");
    rd(4'h8, 8'h80, "R9 status request bits");
    eng_dreq = 4'h1;
    // R12 engine current update
    @(posedge clk); #1 eng_cur_we = 1; eng_cur_ch = 1; eng_cur_addr = 16'h2000; eng_cur_cnt = 16'h0003;
    @(posedge clk); #1 eng_cur_we = 0;
    rd(4'h2, 8'h00, "R12 engine addr low");
    rd(4'h2, 8'h20, "R12 engine addr high");
    // R10 R11 terminal count on ch1 (autoinit) and ch3
    tc(4'hA);
    chk(cur_addr_all[31:16], 16'h1234, "R11 autoinit addr restore");
    chk(cur_cnt_all[31:16], 16'h0005, "R11 autoinit count restore");
    chk(mask, 4'h8, "R10 mask set only without autoinit");
    chk(sw_req, 4'h0, "R10 request cleared");
    rd(4'h8, 8'h1A, "R9 status TC flags");
    rd(4'h8, 8'h10, "R9 TC cleared by read");
    eng_dreq = 0;
    // R8 pointer clear
    wr(4'h0, 8'hAB); wr(4'hC, 8'h00);
    wr(4'h0, 8'hCD); wr(4'h0, 8'hEF);
    rd(4'h0, 8'hCD, "R8 pointer clear low");
    rd(4'h0, 8'hEF, "R8 pointer clear high");
    // R12 temp
    @(posedge clk); #1 eng_tmp_we = 1; eng_tmp_d = 8'h5A;
    @(posedge clk); #1 eng_tmp_we = 0;
    rd(4'hD, 8'h5A, "R12 temp read");
    // R8 master clear
    wr(4'h9, 8'h05); tc(4'h1); wr(4'h4, 8'h77);
    wr(4'hD, 8'h00);
    chk(mask, 4'hF, "R8 master clear mask");
    chk(cmd, 8'h00, "R8 master clear cmd");
    chk(sw_req, 4'h0, "R8 master clear request");
    rd(4'hD, 8'h00, "R8 master clear temp");
    rd(4'h8, 8'h00, "R8 master clear status");
    rd(4'h4, 8'h77, "R8 master clear pointer low");
    // R12 read outside programming
    @(posedge clk); #1 addr = 4'hD; hlda = 1; cs_n = 0; ior_n = 0;
    @(posedge clk); #1 chk(dout, 8'h00, "R12 no read while hlda");
    ior_n = 1; cs_n = 1; hlda = 0;
    repeat (2) @(posedge clk);
    summary();
  end
endmodule